// File: doc/BRIEF.md
# Miscellaneous-Operation Execute Unit

This block is a single-cycle execute stage for one instruction group, picked by a 4-bit secondary opcode. Each issued instruction reads up to two operands from a 16 x 32-bit general register file, applies one of a small set of operations, and commits at most one result in the same clock edge. The operations are sign extension and saturation at a bit position set by the t field, signed and unsigned minimum and maximum, moves that depend on a zero or sign test, and transfers between general registers and two sparse banks of system registers: a special bank indexed by an 8-bit number and a user bank.

The decoder ahead of the stage hands over the r, s and t register fields, the 8-bit register-number field and two option enables. The stage reports each commit on a registered write-back port and raises an illegal-instruction flag for one cycle when an option is off or when a bank number has no register. A second write port lets other pipeline units load the general register file.

Top module: `misc_exec_unit`

## Requirements
- R1: Opcode 2 writes to r the value of s sign-extended from bit (t+7), so that bits above t+7 copy that bit.
- R2: Opcode 3 writes s to r unchanged when it fits a signed (t+8)-bit range, else 2^(t+7)-1 for non-negative s and -2^(t+7) for negative s.
- R3: Opcodes 4, 5, 6, 7 write to r the signed minimum, signed maximum, unsigned minimum and unsigned maximum of s and t, correct also when r equals s or r equals t.
- R4: Opcodes 8, 9, 10, 11 copy s into r when t is zero, non-zero, negative, non-negative respectively; otherwise no write is made and r keeps its value.
- R5: Opcode 0 copies the special register selected by the 8-bit number into general register t; opcode 1 copies general register t into that special register.
- R6: Opcode 14 copies user register s*16+t into r; opcode 15 copies general register t into the user register selected by the 8-bit number.
- R7: An opcode 0, 1, 14 or 15 that names an unimplemented register raises illegal and changes no register.
- R8: Opcodes 2 to 7 with the miscellaneous option off, and opcodes 12 and 13 with the boolean option off, raise illegal and change no register; with the boolean option on, opcodes 12 and 13 do nothing.
- R9: After reset, illegal and wb_valid are low and every implemented special and user register reads zero.
- R10: The write-back port (wb_valid, wb_idx, wb_data) and illegal are registered and report an instruction one cycle after it is issued; an instruction issued in the next cycle reads the committed value.
- R11: The load port writes ld_data into general register ld_idx at the clock edge when ld_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load-port write enable |
| ld_idx | input | 4 | Load-port register index |
| ld_data | input | 32 | Load-port write data |
| valid | input | 1 | Instruction issued this cycle |
| op2 | input | 4 | Secondary opcode |
| fld_r | input | 4 | r register field |
| fld_s | input | 4 | s register field |
| fld_t | input | 4 | t register field |
| regnum | input | 8 | System-register number field |
| opt_misc | input | 1 | Miscellaneous-operations option enable |
| opt_bool | input | 1 | Boolean option enable |
| wb_valid | output | 1 | A general register was written |
| wb_idx | output | 4 | Index of the written register |
| wb_data | output | 32 | Value written |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
The properties assume that the decoder never issues an instruction and a load to the same general register in one cycle, and that option enables stay steady while an instruction is in flight. The stimulus issues one instruction per cycle with loads only between instructions, changes option enables only between instructions, and reads a register's state back through a zero-test move of the register onto itself, so the values the properties relate always come from committed state.

// File: rtl/misc_exec_pkg.sv
package misc_exec_pkg;
  typedef enum logic [3:0] {
    OP_RSR    = 4'd0,
    OP_WSR    = 4'd1,
    OP_SEXT   = 4'd2,
    OP_CLAMP  = 4'd3,
    OP_MINS   = 4'd4,
    OP_MAXS   = 4'd5,
    OP_MINU   = 4'd6,
    OP_MAXU   = 4'd7,
    OP_MOVEQZ = 4'd8,
    OP_MOVNEZ = 4'd9,
    OP_MOVLTZ = 4'd10,
    OP_MOVGEZ = 4'd11,
    OP_BOOLF  = 4'd12,
    OP_BOOLT  = 4'd13,
    OP_RUR    = 4'd14,
    OP_WUR    = 4'd15
  } op_e;
endpackage

// File: rtl/misc_gpr_file.sv
module misc_gpr_file #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          ex_we,
  input  logic [IW-1:0] ex_idx,
  input  logic [W-1:0]  ex_data,
  input  logic          ld_we,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0]  ld_data,
  input  logic [IW-1:0] ra_idx,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  ra_data,
  output logic [W-1:0]  rb_data
);
  logic [W-1:0] mem [DEPTH];

  // Execute result takes priority over the load port on the same index.
  always_ff @(posedge clk) begin
    if (ld_we && !(ex_we && ex_idx == ld_idx)) mem[ld_idx] <= ld_data;
    if (ex_we) mem[ex_idx] <= ex_data;
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/misc_sys_bank.sv
module misc_sys_bank #(
  parameter int W              = 32,
  parameter int AW             = 8,
  parameter logic [(1<<AW)-1:0] MAP = '0,
  localparam int NUM           = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          rhit,
  output logic          whit
);
  logic [W-1:0] regs [NUM];

  assign rhit  = MAP[raddr];
  assign whit  = MAP[waddr];
  assign rdata = rhit ? regs[raddr] : '0;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM; i++) begin
      if (rst) regs[i] <= '0;
      else if (MAP[i] && we && waddr == AW'(i)) regs[i] <= wdata;
    end
  end
endmodule

// File: rtl/misc_alu.sv
module misc_alu
  import misc_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   pos,
  output logic [W-1:0] res,
  output logic         cond_ok
);
  localparam logic [W-1:0] ONE = W'(1);

  int           ext_sh;
  int           sat_sh;
  logic [W-1:0] shl;
  logic [W-1:0] hi;
  logic [W-1:0] pos_lim;
  logic         fits;
  logic         lt_s;
  logic         lt_u;

  always_comb begin
    ext_sh  = W - 8 - int'(pos);
    sat_sh  = int'(pos) + 7;
    shl     = a << ext_sh;
    hi      = W'($signed(a) >>> sat_sh);
    fits    = (hi == '0) || (hi == '1);
    pos_lim = (ONE << sat_sh) - ONE;
    lt_s    = $signed(a) < $signed(b);
    lt_u    = a < b;
    res     = a;
    cond_ok = 1'b0;
    case (op)
      OP_SEXT:   res = W'($signed(shl) >>> ext_sh);
      OP_CLAMP:  res = fits ? a : (a[W-1] ? ~pos_lim : pos_lim);
      OP_MINS:   res = lt_s ? a : b;
      OP_MAXS:   res = lt_s ? b : a;
      OP_MINU:   res = lt_u ? a : b;
      OP_MAXU:   res = lt_u ? b : a;
      OP_MOVEQZ: cond_ok = (b == '0);
      OP_MOVNEZ: cond_ok = (b != '0);
      OP_MOVLTZ: cond_ok = b[W-1];
      OP_MOVGEZ: cond_ok = !b[W-1];
      default:   res = a;
    endcase
  end
endmodule

// File: rtl/misc_exec_unit.sv
module misc_exec_unit
  import misc_exec_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int NW    = 8,
  parameter logic [(1<<NW)-1:0] SR_MAP = ((1<<NW)'(1) << 3) | ((1<<NW)'(1) << 5) | ((1<<NW)'(1) << 230),
  parameter logic [(1<<NW)-1:0] UR_MAP = ((1<<NW)'(1) << 0) | ((1<<NW)'(1) << 231) | ((1<<NW)'(1) << 255),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [W-1:0]  ld_data,
  input  logic          valid,
  input  logic [3:0]    op2,
  input  logic [IW-1:0] fld_r,
  input  logic [IW-1:0] fld_s,
  input  logic [IW-1:0] fld_t,
  input  logic [NW-1:0] regnum,
  input  logic          opt_misc,
  input  logic          opt_bool,
  output logic          wb_valid,
  output logic [IW-1:0] wb_idx,
  output logic [W-1:0]  wb_data,
  output logic          illegal
);
  op_e          op;
  logic [W-1:0] s_val, t_val, alu_res, sr_rdata, ur_rdata;
  logic         cond_ok, sr_rhit, sr_whit, ur_rhit, ur_whit;
  logic         legal, g_we, sr_we, ur_we;
  logic [IW-1:0] g_idx;
  logic [W-1:0] g_data;

  assign op = op_e'(op2);

  misc_gpr_file #(.W(W), .DEPTH(DEPTH)) u_gpr (
    .clk(clk), .ex_we(g_we), .ex_idx(g_idx), .ex_data(g_data),
    .ld_we(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .ra_idx(fld_s), .rb_idx(fld_t), .ra_data(s_val), .rb_data(t_val)
  );

  misc_alu #(.W(W)) u_alu (
    .op(op), .a(s_val), .b(t_val), .pos(4'(fld_t)), .res(alu_res), .cond_ok(cond_ok)
  );

  misc_sys_bank #(.W(W), .AW(NW), .MAP(SR_MAP)) u_sr (
    .clk(clk), .rst(rst), .we(sr_we), .waddr(regnum), .wdata(t_val),
    .raddr(regnum), .rdata(sr_rdata), .rhit(sr_rhit), .whit(sr_whit)
  );

  misc_sys_bank #(.W(W), .AW(NW), .MAP(UR_MAP)) u_ur (
    .clk(clk), .rst(rst), .we(ur_we), .waddr(regnum), .wdata(t_val),
    .raddr(NW'({fld_s, fld_t})), .rdata(ur_rdata), .rhit(ur_rhit), .whit(ur_whit)
  );

  // Decode: legality and which destination receives the result.
  always_comb begin
    logic gw, sw, uw;
    legal  = 1'b1;
    gw     = 1'b0;
    sw     = 1'b0;
    uw     = 1'b0;
    g_idx  = fld_r;
    g_data = alu_res;
    case (op)
      OP_RSR: begin legal = sr_rhit; gw = sr_rhit; g_idx = fld_t; g_data = sr_rdata; end
      OP_WSR: begin legal = sr_whit; sw = sr_whit; end
      OP_SEXT, OP_CLAMP, OP_MINS, OP_MAXS, OP_MINU, OP_MAXU: begin
        legal = opt_misc;
        gw    = opt_misc;
      end
      OP_MOVEQZ, OP_MOVNEZ, OP_MOVLTZ, OP_MOVGEZ: begin
        gw     = cond_ok;
        g_data = s_val;
      end
      OP_BOOLF, OP_BOOLT: legal = opt_bool;
      OP_RUR: begin legal = ur_rhit; gw = ur_rhit; g_data = ur_rdata; end
      OP_WUR: begin legal = ur_whit; uw = ur_whit; end
      default: legal = 1'b0;
    endcase
    g_we  = valid && gw && !rst;
    sr_we = valid && sw;
    ur_we = valid && uw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      illegal  <= 1'b0;
    end else begin
      wb_valid <= g_we;
      wb_idx   <= g_idx;
      wb_data  <= g_data;
      illegal  <= valid && !legal;
    end
  end

  // R7 / R8: a flagged instruction never reports a commit.
  a_r7_illegal_no_commit: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wb_valid);

  // R5: a special-register read lands in the t register.
  a_r5_rsr_dest: assert property (@(posedge clk) disable iff (rst)
    ($past(valid) && $past(op2) == 4'd0 && wb_valid) |-> wb_idx == $past(fld_t));

  // R4: a zero-test move whose test fails writes nothing.
  a_r4_move_skip: assert property (@(posedge clk) disable iff (rst)
    ($past(valid) && $past(op2) == 4'd8 && $past(t_val) != '0) |-> !wb_valid);

  // R2: a clamp result always lies inside the selected signed range.
  a_r2_clamp_range: assert property (@(posedge clk) disable iff (rst)
    ($past(valid) && $past(op2) == 4'd3 && wb_valid) |->
      ((W'($signed(wb_data) >>> (int'($past(fld_t)) + 7)) == '0) ||
       (W'($signed(wb_data) >>> (int'($past(fld_t)) + 7)) == '1)));

  // R3: signed minimum never exceeds either operand.
  a_r3_min_bound: assert property (@(posedge clk) disable iff (rst)
    ($past(valid) && $past(op2) == 4'd4 && wb_valid) |->
      ($signed(wb_data) <= $signed($past(s_val)) && $signed(wb_data) <= $signed($past(t_val))));

  // R8: boolean-group opcodes never commit a general register.
  a_r8_bool_nowrite: assert property (@(posedge clk) disable iff (rst)
    ($past(valid) && ($past(op2) == 4'd12 || $past(op2) == 4'd13)) |-> !wb_valid);
endmodule

// File: tb/tb_misc_exec_unit.sv
module tb_misc_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic        valid = 1'b0;
  logic [3:0]  op2 = '0, fld_r = '0, fld_s = '0, fld_t = '0;
  logic [7:0]  regnum = '0;
  logic        opt_misc = 1'b1, opt_bool = 1'b1;
  logic        wb_valid, illegal;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic        exp_wb;
    logic [3:0]  exp_idx;
    logic [31:0] exp_data;
    logic        exp_ill;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  misc_exec_unit dut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .valid(valid), .op2(op2), .fld_r(fld_r), .fld_s(fld_s), .fld_t(fld_t),
    .regnum(regnum), .opt_misc(opt_misc), .opt_bool(opt_bool),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal)
  );

  // Monitor: one expected item per issued instruction, compared after the edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (wb_valid !== e.exp_wb || illegal !== e.exp_ill ||
          (e.exp_wb && (wb_idx !== e.exp_idx || wb_data !== e.exp_data))) begin
        failures++;
        $display("FAIL %s: got wb=%0b idx=%0d data=%h ill=%0b, expected wb=%0b idx=%0d data=%h ill=%0b",
                 e.tag, wb_valid, wb_idx, wb_data, illegal,
                 e.exp_wb, e.exp_idx, e.exp_data, e.exp_ill);
      end
    end
  end

  task automatic load(input logic [3:0] idx, input logic [31:0] d);
    ld_en = 1'b1; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] r, input logic [3:0] s,
                       input logic [3:0] t, input logic [7:0] num,
                       input logic ewb, input logic [3:0] eidx, input logic [31:0] edat,
                       input logic eill, input string tag);
    exp_t e;
    op2 = op; fld_r = r; fld_s = s; fld_t = t; regnum = num; valid = 1'b1;
    e.exp_wb = ewb; e.exp_idx = eidx; e.exp_data = edat; e.exp_ill = eill; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    valid = 1'b0;
  endtask

  // Read a register through a zero-test move onto itself (r0 holds zero).
  task automatic peek(input logic [3:0] idx, input logic [31:0] v, input string tag);
    issue(4'd8, idx, idx, 4'd0, 8'd0, 1'b1, idx, v, 1'b0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (wb_valid !== 1'b0 || illegal !== 1'b0) begin
      failures++;
      $display("FAIL R9: reset outputs wb=%0b ill=%0b, expected 0 0", wb_valid, illegal);
    end
    load(0, 32'h0);          load(1, 32'h0000_0180); load(2, 32'hFFFF_FE00);
    load(3, 32'h7FFF_FFFF);  load(4, 32'h8000_0000); load(5, 32'h0000_0005);
    load(6, 32'h1234_5678);  load(9, 32'hFFFF_FFFD); load(10, 32'h0000_0002);
    load(11, 32'hFFFF_FFF9); load(12, 32'h0000_0001); load(13, 32'h0000_AAAA);

    // R9: implemented system registers start at zero
    issue(4'd0, 0, 0, 7, 8'd3, 1'b1, 7, 32'h0, 1'b0, "R9 sr reset");
    issue(4'd14, 7, 0, 0, 8'd0, 1'b1, 7, 32'h0, 1'b0, "R9 ur reset");
    // R1: sign extension
    issue(4'd2, 7, 1, 0, 8'd0, 1'b1, 7, 32'hFFFF_FF80, 1'b0, "R1 sext t0");
    issue(4'd2, 7, 1, 2, 8'd0, 1'b1, 7, 32'h0000_0180, 1'b0, "R1 sext t2");
    issue(4'd2, 7, 6, 15, 8'd0, 1'b1, 7, 32'h0034_5678, 1'b0, "R1 sext t15");
    // R2: clamp
    issue(4'd3, 7, 1, 0, 8'd0, 1'b1, 7, 32'h0000_007F, 1'b0, "R2 clamp pos sat");
    issue(4'd3, 7, 2, 0, 8'd0, 1'b1, 7, 32'hFFFF_FF80, 1'b0, "R2 clamp neg sat");
    issue(4'd3, 7, 5, 0, 8'd0, 1'b1, 7, 32'h0000_0005, 1'b0, "R2 clamp pass");
    issue(4'd3, 7, 1, 2, 8'd0, 1'b1, 7, 32'h0000_0180, 1'b0, "R2 clamp fits t2");
    issue(4'd3, 7, 2, 2, 8'd0, 1'b1, 7, 32'hFFFF_FE00, 1'b0, "R2 clamp min edge");
    issue(4'd3, 7, 3, 15, 8'd0, 1'b1, 7, 32'h003F_FFFF, 1'b0, "R2 clamp t15 pos");
    issue(4'd3, 7, 4, 15, 8'd0, 1'b1, 7, 32'hFFC0_0000, 1'b0, "R2 clamp t15 neg");
    // R3: min / max
    issue(4'd4, 7, 2, 1, 8'd0, 1'b1, 7, 32'hFFFF_FE00, 1'b0, "R3 mins");
    issue(4'd5, 7, 3, 4, 8'd0, 1'b1, 7, 32'h7FFF_FFFF, 1'b0, "R3 maxs");
    issue(4'd6, 7, 3, 4, 8'd0, 1'b1, 7, 32'h7FFF_FFFF, 1'b0, "R3 minu");
    issue(4'd7, 7, 3, 4, 8'd0, 1'b1, 7, 32'h8000_0000, 1'b0, "R3 maxu");
    issue(4'd5, 9, 9, 10, 8'd0, 1'b1, 9, 32'h0000_0002, 1'b0, "R3 maxs r==s");
    issue(4'd4, 12, 11, 12, 8'd0, 1'b1, 12, 32'hFFFF_FFF9, 1'b0, "R3 mins r==t");
    issue(4'd7, 8, 9, 9, 8'd0, 1'b1, 8, 32'h0000_0002, 1'b0, "R3 R10 alias commit");
    // R4: conditional moves
    issue(4'd8, 8, 6, 0, 8'd0, 1'b1, 8, 32'h1234_5678, 1'b0, "R4 moveqz taken");
    issue(4'd8, 13, 6, 5, 8'd0, 1'b0, 0, 32'h0, 1'b0, "R4 moveqz skip");
    issue(4'd9, 8, 5, 5, 8'd0, 1'b1, 8, 32'h0000_0005, 1'b0, "R4 movnez taken");
    issue(4'd10, 8, 6, 2, 8'd0, 1'b1, 8, 32'h1234_5678, 1'b0, "R4 movltz taken");
    issue(4'd10, 13, 6, 1, 8'd0, 1'b0, 0, 32'h0, 1'b0, "R4 movltz skip");
    issue(4'd11, 8, 1, 0, 8'd0, 1'b1, 8, 32'h0000_0180, 1'b0, "R4 movgez zero");
    issue(4'd11, 13, 6, 4, 8'd0, 1'b0, 0, 32'h0, 1'b0, "R4 movgez skip");
    peek(13, 32'h0000_AAAA, "R4 r unchanged");
    // R5: special registers
    issue(4'd1, 0, 0, 6, 8'd3, 1'b0, 0, 32'h0, 1'b0, "R5 wsr 3");
    issue(4'd0, 0, 0, 14, 8'd3, 1'b1, 14, 32'h1234_5678, 1'b0, "R5 rsr 3");
    issue(4'd1, 0, 0, 5, 8'd230, 1'b0, 0, 32'h0, 1'b0, "R5 wsr 230");
    issue(4'd0, 0, 0, 14, 8'd230, 1'b1, 14, 32'h0000_0005, 1'b0, "R5 rsr 230");
    // R6: user registers
    issue(4'd15, 0, 0, 5, 8'd231, 1'b0, 0, 32'h0, 1'b0, "R6 wur 231");
    issue(4'd14, 15, 14, 7, 8'd0, 1'b1, 15, 32'h0000_0005, 1'b0, "R6 rur 231");
    issue(4'd15, 0, 0, 6, 8'd255, 1'b0, 0, 32'h0, 1'b0, "R6 wur 255");
    issue(4'd14, 15, 15, 15, 8'd0, 1'b1, 15, 32'h1234_5678, 1'b0, "R6 rur 255");
    // R7: unimplemented numbers
    issue(4'd0, 0, 0, 14, 8'd4, 1'b0, 0, 32'h0, 1'b1, "R7 rsr unmapped");
    peek(14, 32'h0000_0005, "R7 rsr no write");
    issue(4'd1, 0, 0, 3, 8'd4, 1'b0, 0, 32'h0, 1'b1, "R7 wsr unmapped");
    issue(4'd14, 15, 0, 1, 8'd0, 1'b0, 0, 32'h0, 1'b1, "R7 rur unmapped");
    peek(15, 32'h1234_5678, "R7 rur no write");
    issue(4'd15, 0, 0, 6, 8'd2, 1'b0, 0, 32'h0, 1'b1, "R7 wur unmapped");
    issue(4'd14, 7, 0, 0, 8'd0, 1'b1, 7, 32'h0, 1'b0, "R7 ur0 untouched");
    // R8: option gating
    opt_misc = 1'b0;
    issue(4'd2, 13, 1, 0, 8'd0, 1'b0, 0, 32'h0, 1'b1, "R8 sext gated");
    issue(4'd6, 13, 3, 4, 8'd0, 1'b0, 0, 32'h0, 1'b1, "R8 minu gated");
    opt_misc = 1'b1;
    peek(13, 32'h0000_AAAA, "R8 no write");
    opt_bool = 1'b0;
    issue(4'd12, 13, 1, 0, 8'd0, 1'b0, 0, 32'h0, 1'b1, "R8 bool gated");
    opt_bool = 1'b1;
    issue(4'd13, 13, 1, 0, 8'd0, 1'b0, 0, 32'h0, 1'b0, "R8 bool nop");
    peek(13, 32'h0000_AAAA, "R8 bool no write");
    // R10: back-to-back dependency
    issue(4'd8, 7, 3, 0, 8'd0, 1'b1, 7, 32'h7FFF_FFFF, 1'b0, "R10 first");
    issue(4'd8, 8, 7, 0, 8'd0, 1'b1, 8, 32'h7FFF_FFFF, 1'b0, "R10 dependent");
    // R11: load port
    load(7, 32'h0000_CAFE);
    peek(7, 32'h0000_CAFE, "R11 load");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule